// File: doc/BRIEF.md
# Performance Counter Bank

A bank of six 32-bit event counters for a processor core. Four of the counters are programmable. Each takes an 8-bit event code from a shared event-select register. The fifth counter is wired to retired instructions and the sixth to clock cycles. Each cycle the core reports how many instructions retired (`ret_cnt`) and the state of its run-latch bit. Each counter adds the amount that its decoded event calls for.

Software reaches the bank through a plain write port. The port has no valid/ready handshake because every write is taken in the cycle it is presented, so the port never applies back-pressure. A control register holds three freeze bits and two overflow-enable bits. The bank drives out every counter value, a mask of the counters that are counting cycles right now, and a one-cycle overflow alert.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset every counter reads 0, the control register holds only the global freeze bit, all event codes are 0x00, `cyc_mask` is 0 and `ovf_alert` is low.
- R2: While control bit 0 (global freeze) is set, no counter changes except through a register write.
- R3: Control bit 1 stops counters 1 to 4 only, and control bit 2 stops counters 5 and 6 only.
- R4: Unless frozen, counter 5 adds `ret_cnt` every cycle and counter 6 adds 1 every cycle, whatever the event codes hold.
- R5: On counters 1 to 4, code 0x02 adds `ret_cnt` and code 0x1E adds 1 per cycle.
- R6: Code 0xF0 counts cycles and code 0xFE counts instructions on counter 1 only. On counters 2 to 4 both codes leave the counter idle.
- R7: Code 0xFA on counter 4 adds `ret_cnt` only in cycles where `run_latch` is high. On other counters 0xFA leaves the counter idle, and so does any code not listed here.
- R8: `cyc_mask` bit n is high exactly when counter n (1 to 6) is counting cycles under the current control and event registers, freezes included. Bit 0 is always low.
- R9: `wr_sel` values 0 to 5 address counters 1 to 6, value 6 addresses the control register (bits 4:0), and value 7 addresses the event register. In the event register, byte k (bits 8k+7:8k) is the code for counter k+1. A control or event write governs counting from the cycle after the write.
- R10: A write to a counter replaces that cycle's increment. Counters keep counting past 0x80000000 and wrap modulo 2^32.
- R11: When a counter is at or above 0x80000000 and its overflow enable is set, `ovf_alert` is high for one cycle, one cycle later. Counter 1 uses control bit 3 as its enable. Counters 2 to 6 share control bit 4.
- R12: A counter that has raised the alert raises it again only after software writes it a value below 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ret_cnt | input | RET_W (3) | Instructions retired this cycle |
| run_latch | input | 1 | Run-latch status of the core |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (see R9) |
| wr_data | input | CTR_W (32) | Write data |
| ctr_val | output | 6*CTR_W | Counter values, counter n at bits n*CTR_W-1 down to (n-1)*CTR_W |
| cyc_mask | output | 7 | Cycle-counting mask, bit 0 unused |
| ovf_alert | output | 1 | One-cycle overflow alert |

## Verification
The assertions assume that `wr_sel` and `wr_data` are stable whenever `wr_en` is sampled. They also assume that no counter is written in a cycle where a property expects that counter to hold or to increment. Those properties therefore exclude a write to the counter in their antecedent. The stimulus changes inputs only on the falling clock edge and presents at most one write per cycle. It reaches the overflow threshold by loading values just below 0x80000000 rather than by counting there.

// File: rtl/perf_ctr_pkg.sv
package perf_ctr_pkg;
  localparam int NUM_CTR = 6;
  localparam int NUM_PROG = 4;
  localparam int EVT_W = 8;
  localparam int SEL_W = 3;
  localparam int CTRL_W = 5;
  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd6;
  localparam logic [SEL_W-1:0] SEL_EVT = 3'd7;

  localparam logic [EVT_W-1:0] CODE_INSTR = 8'h02;
  localparam logic [EVT_W-1:0] CODE_CYCLE = 8'h1E;
  localparam logic [EVT_W-1:0] CODE_C1_CYC = 8'hF0;
  localparam logic [EVT_W-1:0] CODE_C1_INS = 8'hFE;
  localparam logic [EVT_W-1:0] CODE_RUN_INS = 8'hFA;

  typedef enum logic [1:0] {
    EV_IDLE,
    EV_INSTR,
    EV_CYCLE,
    EV_INSTR_RUN
  } evt_kind_e;

  typedef struct packed {
    logic ovf_en_rest;
    logic ovf_en_first;
    logic frz_hi;
    logic frz_lo;
    logic frz_all;
  } pmu_ctrl_t;
endpackage

// File: rtl/pcb_regs.sv
module pcb_regs
  import perf_ctr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [SEL_W-1:0]            wr_sel,
  input  logic [DATA_W-1:0]           wr_data,
  output pmu_ctrl_t                   ctrl,
  output logic [NUM_PROG*EVT_W-1:0]   evt_sel
);
  localparam int EVT_BITS = NUM_PROG * EVT_W;

  logic ctrl_we;
  logic evt_we;

  assign ctrl_we = wr_en && (wr_sel == SEL_CTRL);
  assign evt_we = wr_en && (wr_sel == SEL_EVT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= pmu_ctrl_t'(CTRL_W'(1));
      evt_sel <= '0;
    end else begin
      if (ctrl_we) ctrl <= pmu_ctrl_t'(wr_data[CTRL_W-1:0]);
      if (evt_we) evt_sel <= wr_data[EVT_BITS-1:0];
    end
  end

  // R9: configuration only moves on its own write
  a_r9_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl));
  a_r9_evt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_we |=> $stable(evt_sel));
endmodule

// File: rtl/pcb_event_decode.sv
module pcb_event_decode
  import perf_ctr_pkg::*;
#(
  parameter int IDX = 1
) (
  input  logic             frozen,
  input  logic [EVT_W-1:0] code,
  output evt_kind_e        kind
);
  localparam bit IS_FIRST = (IDX == 1);
  localparam bit IS_LAST = (IDX == NUM_PROG);

  always_comb begin
    kind = EV_IDLE;
    if (!frozen) begin
      unique case (code)
        CODE_INSTR:   kind = EV_INSTR;
        CODE_CYCLE:   kind = EV_CYCLE;
        CODE_C1_CYC:  kind = IS_FIRST ? EV_CYCLE : EV_IDLE;
        CODE_C1_INS:  kind = IS_FIRST ? EV_INSTR : EV_IDLE;
        CODE_RUN_INS: kind = IS_LAST ? EV_INSTR_RUN : EV_IDLE;
        default:      kind = EV_IDLE;
      endcase
    end
  end

  // R2 R3: a frozen counter decodes to idle
  always_comb begin
    a_r3_frozen_idle: assert (!frozen || kind == EV_IDLE);
  end
endmodule

// File: rtl/pcb_counter.sv
module pcb_counter
  import perf_ctr_pkg::*;
#(
  parameter int CTR_W = 32,
  parameter int RET_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  evt_kind_e        kind,
  input  logic [RET_W-1:0] ret_cnt,
  input  logic             run_latch,
  input  logic             wr_hit,
  input  logic [CTR_W-1:0] wr_data,
  input  logic             ovf_en,
  output logic [CTR_W-1:0] value,
  output logic             pend
);
  localparam int MSB = CTR_W - 1;

  logic [CTR_W-1:0] inc;
  logic             done_q;

  always_comb begin
    unique case (kind)
      EV_INSTR:     inc = CTR_W'(ret_cnt);
      EV_CYCLE:     inc = CTR_W'(1);
      EV_INSTR_RUN: inc = run_latch ? CTR_W'(ret_cnt) : '0;
      default:      inc = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else if (wr_hit) value <= wr_data;
    else value <= value + inc;
  end

  assign pend = value[MSB] && ovf_en && !done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else if (wr_hit && !wr_data[MSB]) done_q <= 1'b0;
    else if (pend) done_q <= 1'b1;
  end

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> value == $past(wr_data));
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == EV_IDLE && !wr_hit) |=> $stable(value));
  a_r12_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !wr_hit) |=> !pend);
endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
  import perf_ctr_pkg::*;
#(
  parameter int CTR_W = 32,
  parameter int RET_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [RET_W-1:0]         ret_cnt,
  input  logic                     run_latch,
  input  logic                     wr_en,
  input  logic [2:0]               wr_sel,
  input  logic [CTR_W-1:0]         wr_data,
  output logic [NUM_CTR*CTR_W-1:0] ctr_val,
  output logic [NUM_CTR:0]         cyc_mask,
  output logic                     ovf_alert
);
  localparam int LAST_BASE = (NUM_CTR - 1) * CTR_W;

  pmu_ctrl_t                 ctrl;
  logic [NUM_PROG*EVT_W-1:0] evt_sel;
  evt_kind_e                 kind [NUM_CTR];
  logic [NUM_CTR-1:0]        pend;
  logic                      frz_prog;
  logic                      frz_fixed;

  pcb_regs #(.DATA_W(CTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ctrl(ctrl), .evt_sel(evt_sel)
  );

  assign frz_prog = ctrl.frz_all || ctrl.frz_lo;
  assign frz_fixed = ctrl.frz_all || ctrl.frz_hi;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    if (i < NUM_PROG) begin : g_prog
      pcb_event_decode #(.IDX(i + 1)) u_dec (
        .frozen(frz_prog),
        .code(evt_sel[i*EVT_W +: EVT_W]),
        .kind(kind[i])
      );
    end else if (i == NUM_PROG) begin : g_instr
      assign kind[i] = frz_fixed ? EV_IDLE : EV_INSTR;
    end else begin : g_cycle
      assign kind[i] = frz_fixed ? EV_IDLE : EV_CYCLE;
    end

    pcb_counter #(.CTR_W(CTR_W), .RET_W(RET_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .kind(kind[i]), .ret_cnt(ret_cnt),
      .run_latch(run_latch),
      .wr_hit(wr_en && (wr_sel == SEL_W'(i))),
      .wr_data(wr_data),
      .ovf_en((i == 0) ? ctrl.ovf_en_first : ctrl.ovf_en_rest),
      .value(ctr_val[i*CTR_W +: CTR_W]),
      .pend(pend[i])
    );

    assign cyc_mask[i+1] = (kind[i] == EV_CYCLE);
  end

  assign cyc_mask[0] = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_alert <= 1'b0;
    else ovf_alert <= |pend;
  end

  a_r2_global_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.frz_all && !(wr_en && wr_sel < SEL_CTRL)) |=> $stable(ctr_val));
  a_r4_cycle_ctr: assert property (@(posedge clk) disable iff (!rst_n)
    (!frz_fixed && !(wr_en && wr_sel == 3'd5)) |=>
      ctr_val[LAST_BASE +: CTR_W] == CTR_W'($past(ctr_val[LAST_BASE +: CTR_W]) + 1'b1));
  a_r8_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.frz_all |-> cyc_mask == '0);
  a_r11_alert_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_alert) |-> $past(pend != '0));
endmodule

// File: tb/test_perf_ctr_bank.sv
module test_perf_ctr_bank;
  localparam int PERIOD = 10;
  localparam int W = 32;

  typedef struct packed {
    logic        we;
    logic [2:0]  sel;
    logic [31:0] data;
    logic [2:0]  ret;
    logic        rl;
    logic [2:0]  idx;
    logic [31:0] val;
    logic [6:0]  mask;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  // ctrl bits: 0 freeze all, 1 freeze 1-4, 2 freeze 5-6, 3 ovf en c1, 4 ovf en rest
  localparam vec_t TBL [NV] = '{
    '{1'b1, 3'd6, 32'h0,        3'd2, 1'b0, 3'd6, 32'd0,  7'h40, 4'd9},   // R9 unfreeze, late effect
    '{1'b0, 3'd0, 32'h0,        3'd3, 1'b0, 3'd5, 32'd3,  7'h40, 4'd4},   // R4
    '{1'b1, 3'd7, 32'hFA1E02F0, 3'd1, 1'b0, 3'd6, 32'd2,  7'h4A, 4'd8},   // R8
    '{1'b0, 3'd0, 32'h0,        3'd2, 1'b0, 3'd2, 32'd2,  7'h4A, 4'd5},   // R5
    '{1'b0, 3'd0, 32'h0,        3'd3, 1'b1, 3'd4, 32'd3,  7'h4A, 4'd7},   // R7
    '{1'b1, 3'd7, 32'hFEF0FE1E, 3'd1, 1'b1, 3'd1, 32'd3,  7'h42, 4'd9},   // R9
    '{1'b0, 3'd0, 32'h0,        3'd2, 1'b1, 3'd2, 32'd6,  7'h42, 4'd6},   // R6
    '{1'b0, 3'd0, 32'h0,        3'd1, 1'b0, 3'd3, 32'd3,  7'h42, 4'd6},   // R6
    '{1'b1, 3'd6, 32'h2,        3'd1, 1'b0, 3'd1, 32'd6,  7'h40, 4'd3},   // R3
    '{1'b0, 3'd0, 32'h0,        3'd2, 1'b0, 3'd1, 32'd6,  7'h40, 4'd3},   // R3
    '{1'b1, 3'd6, 32'h4,        3'd1, 1'b0, 3'd5, 32'd17, 7'h02, 4'd3},   // R3
    '{1'b0, 3'd0, 32'h0,        3'd2, 1'b0, 3'd6, 32'd10, 7'h02, 4'd3},   // R3
    '{1'b1, 3'd6, 32'h1,        3'd1, 1'b0, 3'd1, 32'd8,  7'h00, 4'd2},   // R2
    '{1'b0, 3'd0, 32'h0,        3'd3, 1'b0, 3'd1, 32'd8,  7'h00, 4'd2},   // R2
    '{1'b1, 3'd1, 32'h1234,     3'd0, 1'b0, 3'd2, 32'h1234, 7'h00, 4'd10}, // R10
    '{1'b1, 3'd7, 32'h02020202, 3'd0, 1'b0, 3'd6, 32'd10, 7'h00, 4'd2},   // R2
    '{1'b1, 3'd6, 32'h0,        3'd1, 1'b0, 3'd3, 32'd3,  7'h40, 4'd9},   // R9
    '{1'b0, 3'd0, 32'h0,        3'd2, 1'b0, 3'd4, 32'd6,  7'h40, 4'd5},   // R5
    '{1'b1, 3'd4, 32'd100,      3'd3, 1'b0, 3'd5, 32'd100, 7'h40, 4'd10}, // R10
    '{1'b0, 3'd0, 32'h0,        3'd1, 1'b0, 3'd5, 32'd101, 7'h40, 4'd4}   // R4
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    ret_cnt = '0;
  logic          run_latch = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_sel = '0;
  logic [W-1:0]  wr_data = '0;
  logic [6*W-1:0] ctr_val;
  logic [6:0]    cyc_mask;
  logic          ovf_alert;

  int n_checks = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  perf_ctr_bank i_perf_ctr_bank (
    .clk(clk), .rst_n(rst_n), .ret_cnt(ret_cnt), .run_latch(run_latch),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctr_val(ctr_val), .cyc_mask(cyc_mask), .ovf_alert(ovf_alert)
  );

  function automatic logic [W-1:0] ctr(int n);
    return ctr_val[(n-1)*W +: W];
  endfunction

  task automatic check(int req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // one clock: drive at falling edge, result visible at the next falling edge
  task automatic step(logic we, logic [2:0] sel, logic [W-1:0] d, logic [2:0] r, logic rl);
    wr_en = we; wr_sel = sel; wr_data = d; ret_cnt = r; run_latch = rl;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; ret_cnt = '0; run_latch = 1'b0;
  endtask

  task automatic count_alerts(int cycles, output int hits);
    hits = 0;
    for (int k = 0; k < cycles; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (ovf_alert) hits++;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    int hits;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, freeze-all holds everything still
    for (int n = 1; n <= 6; n++) check(1, "counter after reset", ctr(n), '0);
    check(1, "mask after reset", W'(cyc_mask), '0);
    check(1, "alert after reset", W'(ovf_alert), '0);
    step(1'b0, 3'd0, '0, 3'd5, 1'b0);
    check(1, "counter 6 frozen by reset control", ctr(6), '0);

    for (int v = 0; v < NV; v++) begin
      step(TBL[v].we, TBL[v].sel, TBL[v].data, TBL[v].ret, TBL[v].rl);
      check(int'(TBL[v].req), $sformatf("vector %0d counter %0d", v, TBL[v].idx),
            ctr(int'(TBL[v].idx)), TBL[v].val);
      check(8, $sformatf("vector %0d mask", v), W'(cyc_mask), W'(TBL[v].mask));
    end

    // R11: counter 1 crosses with its own enable
    step(1'b1, 3'd6, 32'h1, 3'd0, 1'b0);
    step(1'b1, 3'd7, 32'h0000001E, 3'd0, 1'b0);
    step(1'b1, 3'd0, 32'h7FFFFFFF, 3'd0, 1'b0);
    step(1'b1, 3'd5, 32'h7FFFFFFE, 3'd0, 1'b0);
    step(1'b1, 3'd6, 32'h08, 3'd0, 1'b0);
    check(11, "alert before crossing", W'(ovf_alert), '0);
    step(1'b0, 3'd0, '0, 3'd0, 1'b0);
    check(11, "counter 1 at threshold", ctr(1), 32'h80000000);
    check(11, "alert one cycle later", W'(ovf_alert), '0);
    step(1'b0, 3'd0, '0, 3'd0, 1'b0);
    check(11, "alert pulse", W'(ovf_alert), 1);
    step(1'b0, 3'd0, '0, 3'd0, 1'b0);
    check(11, "alert single cycle", W'(ovf_alert), '0);
    check(10, "counter 6 counts past threshold", ctr(6), 32'h80000001);
    // R12 no repeat; R11 counter 6 above threshold but shared enable off
    count_alerts(5, hits);
    check(12, "no repeat alert", W'(hits), 0);
    // R12: rewrite below threshold re-arms counter 1
    step(1'b1, 3'd0, 32'h7FFFFFFE, 3'd0, 1'b0);
    count_alerts(6, hits);
    check(12, "re-armed alert count", W'(hits), 1);
    // R11: shared enable reports counter 6
    step(1'b1, 3'd6, 32'h10, 3'd0, 1'b0);
    count_alerts(4, hits);
    check(11, "shared enable alert count", W'(hits), 1);
    // R10: wrap modulo 2^32
    step(1'b1, 3'd5, 32'hFFFFFFFF, 3'd0, 1'b0);
    step(1'b0, 3'd0, '0, 3'd0, 1'b0);
    check(10, "counter 6 wraps", ctr(6), 32'h0);

    finish_run();
  end
endmodule